// File: doc/BRIEF.md
# Calibrated Fractional Tick Divider

This block turns a single-cycle 512 Hz tick enable, already in the system clock domain, into a 100 Hz tick enable for a fraction-of-seconds counter. It also produces a once-per-second tick and an uncorrected frequency-test tick. One second nominally spans 512 input ticks and carries exactly 100 output ticks. A phase accumulator spreads the output ticks evenly over those input ticks.

A 6-bit calibration value trims the clock. Bit 5 selects the direction and bits 4:0 give a magnitude N. The block counts seconds over a 16-minute cycle. For speeding up, the first N seconds of every 8-minute cycle are shortened to 511 input ticks. For slowing down, the first N seconds of every 16-minute cycle are lengthened to 513 input ticks. All other seconds keep 512 input ticks.

The window control is a four-state machine:
- `ST_WAIT` is the state after reset. The transition *first_tick* leaves it and picks the mode of second 0.
- `ST_NOM` (512), `ST_FAST` (511) and `ST_SLOW` (513) are the run states. The transition *sec_boundary* moves between them when a second ends, picking the mode of the next second.

Top module: `tick_cal_divider`

## Requirements
- R1: After a synchronous active-high reset, all three outputs are low. They stay low until the first input tick that arrives after reset is released, and input ticks seen during reset have no effect.
- R2: Every second carries exactly 100 pulses on `tick100_o`.
- R3: Each output is registered, one clock after the input tick that causes it. `sec_tick_o` is high in the same cycle as the 100th `tick100_o` pulse of a second.
- R4: In every second, including the first, each `tick100_o` pulse comes 5 or 6 input ticks after the previous pulse, or after the start of the second.
- R5: If `cal_i[5]`=1 and N=`cal_i[4:0]` is nonzero, second index s lasts 511 input ticks when (s mod 8·SEC_PER_MIN) < N. Otherwise it lasts 512.
- R6: If `cal_i[5]`=0 and N is nonzero, second index s lasts 513 input ticks when s < N, with s counted over 16·SEC_PER_MIN seconds. Otherwise it lasts 512.
- R7: If N=0, every second lasts 512 input ticks, whatever the value of bit 5.
- R8: `ftest_o` repeats every input tick one clock later, under any calibration. It is low in cycles without an input tick.
- R9: The window of a second is fixed by the `cal_i` value present in the cycle of the previous second's last input tick, or in the cycle of the first tick after reset for second 0. A change in the middle of a second does not alter that second.
- R10: The second index starts at 0 after reset and wraps to 0 after 16·SEC_PER_MIN seconds. Positive correction therefore recurs every 8·SEC_PER_MIN seconds and negative correction every 16·SEC_PER_MIN seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick512_i | input | 1 | Single-cycle 512 Hz tick enable |
| cal_i | input | 6 | Calibration: bit 5 direction (1 = faster), bits 4:0 magnitude N |
| tick100_o | output | 1 | 100 Hz tick enable for the fraction counter |
| sec_tick_o | output | 1 | One-second tick |
| ftest_o | output | 1 | Uncorrected 512 Hz frequency-test tick |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the 100th fractional pulse and the second tick. Every second the bench applies is examined at that closing tick: the bench requires `tick100_o` to be high whenever `sec_tick_o` is, and requires the second to close exactly on the input tick predicted for its window.

The second pair is a calibration write and the last input tick of a second. The bench changes `cal_i` in precisely that tick's cycle and checks that the new value sets the length of the following second. A write made mid-second is shown to leave the running second untouched.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_NOM  = 2'd1,
        ST_FAST = 2'd2,
        ST_SLOW = 2'd3
    } win_state_t;
endpackage

// File: rtl/cdiv_sec_ctr.sv
module cdiv_sec_ctr #(
    parameter int SECS = 960,
    localparam int IW = $clog2(SECS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic [IW-1:0] idx_nxt
);
    // the index that the coming second will carry
    always_comb begin
        if (idx == IW'(SECS - 1)) idx_nxt = '0;
        else                      idx_nxt = idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)      idx <= '0;
        else if (adv) idx <= idx_nxt;
    end

    assert_idx_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (adv && idx == IW'(SECS - 1)) |=> (idx == '0));
    assert_idx_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(idx));
endmodule

// File: rtl/cdiv_win_fsm.sv
module cdiv_win_fsm
    import cdiv_pkg::*;
#(
    parameter int IN_PER_SEC = 512,
    parameter int POS_SECS   = 480,
    parameter int IW         = 10,
    parameter int WW         = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          sec_done,
    input  logic [5:0]    cal,
    input  logic [IW-1:0] idx,
    input  logic [IW-1:0] idx_nxt,
    output logic [WW-1:0] win
);
    win_state_t state, state_nxt, mode;

    // mode of the second with index s under calibration value c
    function automatic win_state_t pick(input logic [5:0] c, input logic [IW-1:0] s);
        logic [IW-1:0] fold;
        fold = (s >= IW'(POS_SECS)) ? s - IW'(POS_SECS) : s;
        if (c[4:0] == 5'd0)                 return ST_NOM;
        else if (c[5] && int'(fold) < int'(c[4:0])) return ST_FAST;
        else if (!c[5] && int'(s) < int'(c[4:0]))   return ST_SLOW;
        else                                return ST_NOM;
    endfunction

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT:                  if (tick)     state_nxt = pick(cal, idx);     // first_tick
            ST_NOM, ST_FAST, ST_SLOW: if (sec_done) state_nxt = pick(cal, idx_nxt); // sec_boundary
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT;
        else     state <= state_nxt;
    end

    // window of the running second; in ST_WAIT the first tick already uses it
    always_comb begin
        mode = (state == ST_WAIT) ? pick(cal, idx) : state;
        unique case (mode)
            ST_FAST: win = WW'(IN_PER_SEC - 1);
            ST_SLOW: win = WW'(IN_PER_SEC + 1);
            default: win = WW'(IN_PER_SEC);
        endcase
    end

    assert_no_return_to_wait_R1: assert property (@(posedge clk) disable iff (rst)
        (state != ST_WAIT) |=> (state != ST_WAIT));
    assert_hold_mid_second_R9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_WAIT && !sec_done) |=> $stable(state));
    assert_zero_mag_nominal_R7: assert property (@(posedge clk) disable iff (rst)
        (state != ST_WAIT && sec_done && cal[4:0] == 5'd0) |=> (state == ST_NOM));
    assert_pos_never_slow_R5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_WAIT && sec_done && cal[5]) |=> (state != ST_SLOW));
endmodule

// File: rtl/cdiv_frac_acc.sv
module cdiv_frac_acc #(
    parameter int OUT_PER_SEC = 100,
    parameter int WW          = 10,
    localparam int CW = $clog2(OUT_PER_SEC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [WW-1:0] win,
    output logic          pulse,
    output logic          last
);
    logic [WW-1:0] acc, acc_sum;
    logic [CW-1:0] pcnt;

    always_comb begin
        acc_sum = acc + WW'(OUT_PER_SEC);
        pulse   = tick && (acc_sum >= win);
        last    = pulse && (pcnt == CW'(OUT_PER_SEC - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            pcnt <= '0;
        end else if (tick) begin
            if (last) begin
                acc  <= '0;
                pcnt <= '0;
            end else if (pulse) begin
                acc  <= acc_sum - win;
                pcnt <= pcnt + 1'b1;
            end else begin
                acc  <= acc_sum;
            end
        end
    end

    assert_acc_below_win_R4: assert property (@(posedge clk) disable iff (rst)
        acc < win);
    assert_last_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        last |=> (acc == '0 && pcnt == '0));
endmodule

// File: rtl/tick_cal_divider.sv
module tick_cal_divider #(
    parameter int IN_PER_SEC  = 512,
    parameter int OUT_PER_SEC = 100,
    parameter int SEC_PER_MIN = 60,
    parameter int POS_MIN     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick512_i,
    input  logic [5:0] cal_i,
    output logic       tick100_o,
    output logic       sec_tick_o,
    output logic       ftest_o
);
    localparam int POS_SECS = POS_MIN * SEC_PER_MIN;
    localparam int CYC_SECS = 2 * POS_SECS;
    localparam int IW       = $clog2(CYC_SECS);
    localparam int WW       = $clog2(IN_PER_SEC + OUT_PER_SEC + 2);

    logic [IW-1:0] idx, idx_nxt;
    logic [WW-1:0] win;
    logic          pulse, last;

    cdiv_sec_ctr #(.SECS(CYC_SECS)) u_sec (
        .clk(clk), .rst(rst), .adv(last), .idx(idx), .idx_nxt(idx_nxt)
    );

    cdiv_win_fsm #(.IN_PER_SEC(IN_PER_SEC), .POS_SECS(POS_SECS), .IW(IW), .WW(WW)) u_fsm (
        .clk(clk), .rst(rst), .tick(tick512_i), .sec_done(last), .cal(cal_i),
        .idx(idx), .idx_nxt(idx_nxt), .win(win)
    );

    cdiv_frac_acc #(.OUT_PER_SEC(OUT_PER_SEC), .WW(WW)) u_acc (
        .clk(clk), .rst(rst), .tick(tick512_i), .win(win), .pulse(pulse), .last(last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick100_o  <= 1'b0;
            sec_tick_o <= 1'b0;
            ftest_o    <= 1'b0;
        end else begin
            tick100_o  <= pulse;
            sec_tick_o <= last;
            ftest_o    <= tick512_i;
        end
    end

    assert_sec_with_frac_R3: assert property (@(posedge clk) disable iff (rst)
        sec_tick_o |-> tick100_o);
    assert_frac_needs_tick_R8: assert property (@(posedge clk) disable iff (rst)
        tick100_o |-> ftest_o);
endmodule

// File: tb/sim_tick_cal_divider.sv
module sim_tick_cal_divider;
    localparam int SPM  = 4;
    localparam int POSS = 8 * SPM;
    localparam int CYCS = 16 * SPM;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick512_i = 1'b0;
    logic [5:0] cal_i = 6'd0;
    logic       tick100_o, sec_tick_o, ftest_o;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    tick_cal_divider #(.SEC_PER_MIN(SPM)) u0 (
        .clk(clk), .rst(rst), .tick512_i(tick512_i), .cal_i(cal_i),
        .tick100_o(tick100_o), .sec_tick_o(sec_tick_o), .ftest_o(ftest_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick512_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one second: drive ticks until sec_tick_o, judge its length and pulses
    task automatic run_second(input int exp_w, input int chg_at, input logic [5:0] nv,
                              input string req);
        int  k = 0, pulses = 0, gap = 0, bad_gap = 0, bad_ft = 0, bad_idle = 0;
        bit  seen = 1'b0;
        while (!seen && k < exp_w + 8) begin
            k++;
            if (k == chg_at) cal_i = nv;
            tick512_i = 1'b1;
            @(negedge clk);
            tick512_i = 1'b0;
            if (!ftest_o) bad_ft++;
            gap++;
            if (tick100_o) begin
                if (gap < 5 || gap > 6) bad_gap++;
                gap = 0;
                pulses++;
            end
            if (sec_tick_o) begin
                seen = 1'b1;
                chk(tick100_o, "R3 sec tick without 100th pulse", int'(tick100_o), 1);
            end
            if (!seen && (k % 97) == 0) begin
                @(negedge clk);
                if (tick100_o || sec_tick_o || ftest_o) bad_idle++;
            end
        end
        chk(seen && k == exp_w, req, k, exp_w);
        chk(pulses == 100, "R2 pulses per second", pulses, 100);
        chk(bad_gap == 0, "R4 pulse spacing", bad_gap, 0);
        chk(bad_ft == 0 && bad_idle == 0, "R8 frequency-test echo", bad_ft + bad_idle, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick512_i = 1'b1;
        @(negedge clk);
        chk(!tick100_o && !sec_tick_o && !ftest_o, "R1 outputs during reset",
            {tick100_o, sec_tick_o, ftest_o}, 0);
        tick512_i = 1'b0;
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!tick100_o && !sec_tick_o && !ftest_o, "R1 idle after reset",
                {tick100_o, sec_tick_o, ftest_o}, 0);
        end
    endtask

    task automatic t_zero_mag();
        do_reset();
        cal_i = 6'b100000;
        for (int s = 0; s < 2; s++) run_second(512, 0, 6'd0, "R7 N=0 positive sign");
        cal_i = 6'b000000;
        run_second(512, 0, 6'd0, "R7 N=0 negative sign");
    endtask

    task automatic t_positive();
        do_reset();
        cal_i = 6'b100011;
        for (int s = 0; s < POSS + 2; s++)
            run_second(((s % POSS) < 3) ? 511 : 512, 0, 6'd0,
                       (s >= POSS) ? "R10 positive repeat" : "R5 positive window");
    endtask

    task automatic t_negative();
        do_reset();
        cal_i = 6'b000010;
        for (int s = 0; s < CYCS + 2; s++)
            run_second(((s % CYCS) < 2) ? 513 : 512, 0, 6'd0,
                       (s >= CYCS) ? "R10 negative repeat" : "R6 negative window");
    endtask

    task automatic t_sampling();
        do_reset();
        cal_i = 6'b000000;
        run_second(512, 300, 6'b111111, "R9 mid-second write ignored");
        run_second(511, 511, 6'b000100, "R9 new value takes next second");
        run_second(513, 100, 6'b000000, "R9 boundary write applied");
        run_second(512, 0, 6'd0, "R9 later write applied");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_zero_mag();
        t_positive();
        t_negative();
        t_sampling();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule